// File: doc/BRIEF.md
# Auxiliary RAM Window Decoder with Nametable Mirroring Control

This block sits on an 8-bit CPU bus and decodes three extra RAM windows. The first window covers $4800-$4FFF and the second covers $5000-$5FFF. Each of these two can be switched off at run time, so that an expansion sound device can own that range instead. The third window, $6000-$7FFF, is always on and is never write-protected.

Two write-only configuration registers share the $5FEC/$5FED pair. The register at $5FEC holds the enables for the two switchable windows. The register at $5FED picks horizontal or vertical nametable mirroring. The block drives one chip select for each window and read/write enables for the RAM data path. It also drives the nametable bank line, which it takes from a PPU address bit chosen by the mirroring mode.

Top module: `auxmem_ctl`

## Requirements
- R1: After reset both switchable windows are enabled, and mirroring is horizontal, so `nt_bank` follows `ppu_addr[11]`.
- R2: While enable bit 0 is 1, `ram_cs_a` is high for every address from $4800 to $4FFF, and for no other address.
- R3: While enable bit 1 is 1, `ram_cs_b` is high for addresses $5000-$5FFF except $5FEC and $5FED. Those two addresses select no RAM.
- R4: `ram_cs_w` is high for $6000-$7FFF whatever the enable register holds.
- R5: A write to $5FEC loads enable bit 0 (window $4800) and enable bit 1 (window $5000) from the data bus. The new value governs decoding from the cycle after the write edge.
- R6: A disabled window asserts neither its chip select nor `ram_rd_en` on reads, and does not assert `ram_wr_en` on writes.
- R7: A write to $5FED loads the mirroring mode from data bit 7, where 0 means horizontal and 1 means vertical. In vertical mode `nt_bank` follows `ppu_addr[10]`. The other data bits have no effect.
- R8: Reads of $5FEC/$5FED, and writes to any other address, leave both registers unchanged.
- R9: At most one chip select is high at a time. `ram_rd_en` equals `cpu_rd` while a chip select is high, and `ram_wr_en` equals `cpu_wr` while a chip select is high. Addresses outside all windows select nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| ppu_addr | input | 14 | PPU address |
| ram_cs_a | output | 1 | Select, $4800-$4FFF RAM |
| ram_cs_b | output | 1 | Select, $5000-$5FFF RAM |
| ram_cs_w | output | 1 | Select, $6000-$7FFF RAM |
| ram_rd_en | output | 1 | RAM may drive the data bus |
| ram_wr_en | output | 1 | RAM write enable |
| nt_bank | output | 1 | Mirrored nametable bank line |

## Verification
The chip selects, the RAM enables and `nt_bank` are combinational from the bus and the register state, so each is due in the same cycle as the address that causes it. The bench drives the address on a falling edge and samples 2 ns later, before the next rising edge. A register write takes effect at the rising edge where the strobe is high. The bench therefore drops the strobe on the next falling edge and probes the new behaviour only after that edge, never in the write cycle itself.

// File: rtl/auxmem_pkg.sv
package auxmem_pkg;
  localparam int ADDR_W  = 16;
  localparam int DATA_W  = 8;
  localparam int PPU_W   = 14;
  localparam int NUM_WIN = 3;
  localparam int NUM_SW  = 2;   // switchable windows

  typedef enum int {WIN_SND_A = 0, WIN_SND_B = 1, WIN_WORK = 2} win_e;

  function automatic logic [ADDR_W-1:0] win_lo(int i);
    case (i)
      WIN_SND_A: return 16'h4800;
      WIN_SND_B: return 16'h5000;
      default:   return 16'h6000;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] win_hi(int i);
    case (i)
      WIN_SND_A: return 16'h4FFF;
      WIN_SND_B: return 16'h5FFF;
      default:   return 16'h7FFF;
    endcase
  endfunction

  function automatic logic in_range(logic [ADDR_W-1:0] a,
                                    logic [ADDR_W-1:0] lo,
                                    logic [ADDR_W-1:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  function automatic logic mirror_line(logic vert, logic [PPU_W-1:0] pa);
    return vert ? pa[10] : pa[11];
  endfunction
endpackage

// File: rtl/auxmem_cfg_regs.sv
module auxmem_cfg_regs
  import auxmem_pkg::*;
#(
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'h5FEC,
  parameter logic [ADDR_W-1:0] MIRR_ADDR = 16'h5FED,
  parameter int                MIRR_BIT  = 7,
  parameter logic [NUM_SW-1:0] EN_RST    = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr,
  output logic [NUM_SW-1:0] win_en,
  output logic              vert_mode,
  output logic              reg_hit
);
  logic ctrl_wr, mirr_wr;

  assign ctrl_wr = wr && (addr == CTRL_ADDR);
  assign mirr_wr = wr && (addr == MIRR_ADDR);
  assign reg_hit = (addr == CTRL_ADDR) || (addr == MIRR_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_en    <= EN_RST;
      vert_mode <= 1'b0;
    end else begin
      if (ctrl_wr) win_en    <= wdata[NUM_SW-1:0];
      if (mirr_wr) vert_mode <= wdata[MIRR_BIT];
    end
  end

  AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> win_en == $past(wdata[NUM_SW-1:0])); // R5
  AST_MIRR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    mirr_wr |=> vert_mode == $past(wdata[MIRR_BIT])); // R7
  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(win_en)); // R8
  AST_MIRR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !mirr_wr |=> $stable(vert_mode)); // R8
endmodule

// File: rtl/auxmem_win_decode.sv
module auxmem_win_decode
  import auxmem_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               rd,
  input  logic               wr,
  input  logic [NUM_SW-1:0]  win_en,
  input  logic               reg_hit,
  output logic [NUM_WIN-1:0] cs,
  output logic               rd_en,
  output logic               wr_en
);
  logic [NUM_WIN-1:0] en_all;
  logic [NUM_WIN-1:0] hit;
  logic               any_cs;

  assign en_all = {1'b1, win_en};

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    if (i == WIN_SND_B) begin : g_excl
      assign hit[i] = in_range(addr, win_lo(i), win_hi(i)) && !reg_hit;
    end else begin : g_plain
      assign hit[i] = in_range(addr, win_lo(i), win_hi(i));
    end
    assign cs[i] = hit[i] && en_all[i];
  end

  assign any_cs = |cs;
  assign rd_en  = rd && any_cs;
  assign wr_en  = wr && any_cs;

  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs)); // R9
  AST_REG_NO_RAM: assert property (@(posedge clk) disable iff (!rst_n)
    reg_hit |-> cs == '0); // R3
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (win_en == '0) |-> !cs[WIN_SND_A] && !cs[WIN_SND_B]); // R6
endmodule

// File: rtl/auxmem_nt_mirror.sv
module auxmem_nt_mirror
  import auxmem_pkg::*;
(
  input  logic             vert_mode,
  input  logic [PPU_W-1:0] ppu_addr,
  output logic             nt_bank
);
  assign nt_bank = mirror_line(vert_mode, ppu_addr);
endmodule

// File: rtl/auxmem_ctl.sv
module auxmem_ctl
  import auxmem_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [PPU_W-1:0]  ppu_addr,
  output logic              ram_cs_a,
  output logic              ram_cs_b,
  output logic              ram_cs_w,
  output logic              ram_rd_en,
  output logic              ram_wr_en,
  output logic              nt_bank
);
  logic [NUM_SW-1:0]  win_en;
  logic               vert_mode;
  logic               reg_hit;
  logic [NUM_WIN-1:0] cs;

  auxmem_cfg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .addr(cpu_addr), .wdata(cpu_wdata),
    .wr(cpu_wr), .win_en(win_en), .vert_mode(vert_mode), .reg_hit(reg_hit)
  );

  auxmem_win_decode u_dec (
    .clk(clk), .rst_n(rst_n), .addr(cpu_addr), .rd(cpu_rd), .wr(cpu_wr),
    .win_en(win_en), .reg_hit(reg_hit), .cs(cs),
    .rd_en(ram_rd_en), .wr_en(ram_wr_en)
  );

  auxmem_nt_mirror u_mir (
    .vert_mode(vert_mode), .ppu_addr(ppu_addr), .nt_bank(nt_bank)
  );

  assign ram_cs_a = cs[WIN_SND_A];
  assign ram_cs_b = cs[WIN_SND_B];
  assign ram_cs_w = cs[WIN_WORK];

  AST_WORK_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:13] == 3'b011) |-> ram_cs_w); // R4
  AST_RD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    ram_rd_en |-> cpu_rd && (ram_cs_a || ram_cs_b || ram_cs_w)); // R9
  AST_WR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    ram_wr_en |-> cpu_wr && (ram_cs_a || ram_cs_b || ram_cs_w)); // R6
endmodule

// File: tb/auxmem_ctl_test.sv
module auxmem_ctl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_rd = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [13:0] ppu_addr = '0;
  logic ram_cs_a, ram_cs_b, ram_cs_w, ram_rd_en, ram_wr_en, nt_bank;

  int checks = 0;
  int errors = 0;
  logic m_ena = 1'b1, m_enb = 1'b1, m_vert = 1'b0;

  always #10 clk = ~clk;

  auxmem_ctl uut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .ppu_addr(ppu_addr),
    .ram_cs_a(ram_cs_a), .ram_cs_b(ram_cs_b), .ram_cs_w(ram_cs_w),
    .ram_rd_en(ram_rd_en), .ram_wr_en(ram_wr_en), .nt_bank(nt_bank)
  );

  // bench model: {cs_a, cs_b, cs_w, rd_en, wr_en}
  function automatic logic [4:0] model(logic [15:0] a, logic rd, logic wr);
    logic wa, wb, ww, any;
    wa  = (a[15:11] == 5'b01001) && m_ena;
    wb  = (a[15:12] == 4'h5) && (a[15:1] != 15'h2FF6) && m_enb;
    ww  = (a[15:13] == 3'b011);
    any = wa | wb | ww;
    return {wa, wb, ww, rd & any, wr & any};
  endfunction

  task automatic check(logic [4:0] act, logic [4:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic probe(logic [15:0] a, logic rd, logic wr, string tag);
    @(negedge clk);
    cpu_addr = a; cpu_rd = rd; cpu_wr = wr; cpu_wdata = 8'h00;
    #2;
    check({ram_cs_a, ram_cs_b, ram_cs_w, ram_rd_en, ram_wr_en},
          model(a, rd, wr), tag);
    @(negedge clk);
    cpu_rd = 1'b0; cpu_wr = 1'b0;
  endtask

  task automatic bus_write(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
    if (a == 16'h5FEC) begin m_ena = d[0]; m_enb = d[1]; end
    if (a == 16'h5FED) m_vert = d[7];
  endtask

  task automatic check_nt(logic [13:0] pa, string tag);
    logic exp;
    ppu_addr = pa;
    #2;
    exp = m_vert ? pa[10] : pa[11];
    check({4'b0, nt_bank}, {4'b0, exp}, tag);
  endtask

  task automatic t_reset;
    probe(16'h4800, 1'b1, 1'b0, "R1 window A on after reset");
    probe(16'h5000, 1'b1, 1'b0, "R1 window B on after reset");
    check_nt(14'h0800, "R1 horizontal after reset a11=1");
    check_nt(14'h0400, "R1 horizontal after reset a10=1");
  endtask

  task automatic t_bounds;
    probe(16'h47FF, 1'b1, 1'b0, "R2 below window A");
    probe(16'h4FFF, 1'b1, 1'b0, "R2 top of window A");
    probe(16'h4C00, 1'b0, 1'b1, "R2 write inside window A");
    probe(16'h5FEB, 1'b1, 1'b0, "R3 below register pair");
    probe(16'h5FEC, 1'b1, 1'b0, "R3 ctrl register no RAM");
    probe(16'h5FED, 1'b0, 1'b0, "R3 mirror register no RAM");
    probe(16'h5FEE, 1'b1, 1'b0, "R3 above register pair");
    probe(16'h5FFF, 1'b0, 1'b1, "R3 top of window B");
    probe(16'h6000, 1'b1, 1'b0, "R4 bottom of work RAM");
    probe(16'h7FFF, 1'b0, 1'b1, "R4 top of work RAM");
    probe(16'h8000, 1'b1, 1'b0, "R9 above all windows");
    probe(16'h4000, 1'b0, 1'b1, "R9 below all windows");
    probe(16'h6800, 1'b0, 1'b0, "R9 no strobe no enable");
  endtask

  task automatic t_disable;
    bus_write(16'h5FEC, 8'h00);
    probe(16'h4800, 1'b1, 1'b0, "R6 window A off read");
    probe(16'h4C00, 1'b0, 1'b1, "R6 window A off write");
    probe(16'h5100, 1'b1, 1'b0, "R6 window B off read");
    probe(16'h5FFF, 1'b0, 1'b1, "R6 window B off write");
    probe(16'h7000, 1'b0, 1'b1, "R4 work RAM with windows off");
    bus_write(16'h5FEC, 8'h02);
    probe(16'h4900, 1'b1, 1'b0, "R5 only B enabled, A quiet");
    probe(16'h5200, 1'b1, 1'b0, "R5 only B enabled, B on");
    bus_write(16'h5FEC, 8'h01);
    probe(16'h4900, 1'b0, 1'b1, "R5 only A enabled, A on");
    probe(16'h5200, 1'b0, 1'b1, "R5 only A enabled, B quiet");
    bus_write(16'h5FEC, 8'hFF);
    probe(16'h4800, 1'b1, 1'b0, "R5 both re-enabled A");
    probe(16'h5000, 1'b1, 1'b0, "R5 both re-enabled B");
  endtask

  task automatic t_mirror;
    bus_write(16'h5FED, 8'h80);
    check_nt(14'h0400, "R7 vertical a10=1");
    check_nt(14'h0800, "R7 vertical a11=1");
    bus_write(16'h5FED, 8'h7F);
    check_nt(14'h0800, "R7 low bits ignored, horizontal");
    check_nt(14'h0400, "R7 low bits ignored a10=1");
    bus_write(16'h5FED, 8'h80);
    probe(16'h5FED, 1'b1, 1'b0, "R8 read of mirror register");
    check_nt(14'h0400, "R8 mode kept after read");
    bus_write(16'h5FEE, 8'h00);
    check_nt(14'h0400, "R8 mode kept after write to 5FEE");
    bus_write(16'h5FEB, 8'h00);
    probe(16'h4800, 1'b1, 1'b0, "R8 enables kept after write to 5FEB");
    probe(16'h5FEC, 1'b1, 1'b0, "R8 read of ctrl register");
    probe(16'h5400, 1'b1, 1'b0, "R8 enables kept after ctrl read");
  endtask

  initial begin
    #(20 * 20000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_bounds();
    t_disable();
    t_mirror();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule